// File: doc/BRIEF.md
# JTAG Instruction and Data-Register Selector

This block is the test access port front end of a chip. A sixteen-state controller walks the standard state graph under TMS on the rising edge of TCK. A four-bit instruction register picks which data register sits between TDI and TDO. Four data paths can be chosen: an external boundary-scan chain, a 32-bit identification register, a one-bit reset register and a one-bit bypass register. All shift registers move least significant bit first.

The boundary-scan cells live outside the block. The block gives them a select line that is high while the boundary-scan opcode is active, plus the raw Capture-DR, Shift-DR and Update-DR state strobes. It takes back their serial output. The reset register takes its bit from TDI during Shift-DR. While it holds a 1, the core reset output stays asserted. That core reset output is the OR of the held bit and a system reset input, so the tester can park the chip in reset with its pins tri-stated.

TDO and its enable are retimed to the falling edge of TCK. The enable is high only while the controller is in Shift-IR or Shift-DR. The active instruction changes on the falling edge of TCK in Update-IR.

Top module: `tapSelect`

## Requirements
- R1: While trstN is low, or after five rising TCK edges with TMS high, the controller is in Test-Logic-Reset. In that state the active instruction becomes IDCODE (4'h1), resetHold clears to 0, bsrSelect is 0 and tdoEn is 0.
- R2: The controller follows the 16-state TAP graph. captureDr, shiftDr and updateDr are each high exactly while the controller is in Capture-DR, Shift-DR and Update-DR.
- R3: The instruction register is 4 bits wide. It loads 4'b0001 in Capture-IR and shifts TDI in at bit 3 while bit 0 leaves first. The shifted value becomes the active instruction on the falling TCK edge in Update-IR, and not before.
- R4: With opcode 4'h1, the data path is the 32-bit identification register. It loads the ID value in Capture-DR and shifts it out bit 0 first. Bit 0 of the ID value is always 1. The ID is built as version in bits 31:28, part in bits 27:12 and manufacturer in bits 11:1.
- R5: With opcode 4'h0, bsrSelect is 1 and TDO carries bsrTdo. For every other opcode, bsrSelect is 0.
- R6: With opcode 4'hC, the data path is the one-bit reset register. On every rising TCK edge in Shift-DR it loads TDI, and TDO shows the value it held before that edge.
- R7: resetHold keeps its value when the instruction changes. coreReset is high whenever sysResetIn or resetHold is high.
- R8: Opcode 4'hF, and every opcode other than 4'h0, 4'h1 and 4'hC, selects the one-bit bypass register. It loads 0 in Capture-DR, so TDO returns TDI delayed by one shift.
- R9: tdo and tdoEn change only on the falling edge of TCK. tdoEn is 1 exactly after a falling edge in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid while tdoEn is high |
| tdoEn | output | 1 | Output enable for tdo; low means tri-stated |
| bsrTdo | input | 1 | Serial output of the external boundary-scan chain |
| bsrSelect | output | 1 | High while the boundary-scan opcode is active |
| captureDr | output | 1 | Controller is in Capture-DR |
| shiftDr | output | 1 | Controller is in Shift-DR |
| updateDr | output | 1 | Controller is in Update-DR |
| sysResetIn | input | 1 | Other reset sources of the chip |
| resetHold | output | 1 | Content of the reset register |
| coreReset | output | 1 | Internal reset: sysResetIn OR resetHold |

## Verification
Within a single Shift-DR edge the reset register must do two things: drive its old bit out on TDO and take a new bit from TDI. The bench provokes this with one-bit and two-bit scans under opcode 4'hC. It judges the result by comparing the bit on TDO against the value held before the scan, and by checking resetHold right after each edge. The second overlap is the instruction change in Update-IR coinciding with the start of the next state. The bench samples bsrSelect in both Exit1-IR and Update-IR to show where the switch happens.

// File: rtl/tapPkg.sv
package tapPkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] OP_RSTREG  = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    stTlr, stIdle, stSelDr, stCapDr, stShDr, stEx1Dr, stPauDr, stEx2Dr, stUpdDr,
    stSelIr, stCapIr, stShIr, stEx1Ir, stPauIr, stEx2Ir, stUpdIr
  } tapState_e;

  typedef enum logic [1:0] {
    selBoundary, selIdent, selRstReg, selBypass
  } drSel_e;

  typedef struct packed {
    logic tlr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strobe
);

  tapState_e state, stateNext;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= stTlr;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      stTlr:   stateNext = tms ? stTlr   : stIdle;
      stIdle:  stateNext = tms ? stSelDr : stIdle;
      stSelDr: stateNext = tms ? stSelIr : stCapDr;
      stCapDr: stateNext = tms ? stEx1Dr : stShDr;
      stShDr:  stateNext = tms ? stEx1Dr : stShDr;
      stEx1Dr: stateNext = tms ? stUpdDr : stPauDr;
      stPauDr: stateNext = tms ? stEx2Dr : stPauDr;
      stEx2Dr: stateNext = tms ? stUpdDr : stShDr;
      stUpdDr: stateNext = tms ? stSelDr : stIdle;
      stSelIr: stateNext = tms ? stTlr   : stCapIr;
      stCapIr: stateNext = tms ? stEx1Ir : stShIr;
      stShIr:  stateNext = tms ? stEx1Ir : stShIr;
      stEx1Ir: stateNext = tms ? stUpdIr : stPauIr;
      stPauIr: stateNext = tms ? stEx2Ir : stPauIr;
      stEx2Ir: stateNext = tms ? stUpdIr : stShIr;
      stUpdIr: stateNext = tms ? stSelDr : stIdle;
      default: stateNext = stTlr;
    endcase
  end

  always_comb begin
    strobe.tlr       = (state == stTlr);
    strobe.captureIr = (state == stCapIr);
    strobe.shiftIr   = (state == stShIr);
    strobe.updateIr  = (state == stUpdIr);
    strobe.captureDr = (state == stCapDr);
    strobe.shiftDr   = (state == stShDr);
    strobe.updateDr  = (state == stUpdDr);
  end

endmodule

// File: rtl/tapDecode.sv
module tapDecode
  import tapPkg::*;
(
  input  logic [IR_W-1:0] instr,
  output drSel_e          sel,
  output logic            bsrSelect
);

  always_comb begin
    unique case (instr)
      OP_EXTEST: sel = selBoundary;
      OP_IDCODE: sel = selIdent;
      OP_RSTREG: sel = selRstReg;
      default:   sel = selBypass;
    endcase
  end

  assign bsrSelect = (sel == selBoundary);

endmodule

// File: rtl/tapDatapath.sv
module tapDatapath
  import tapPkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStrobe_t      strobe,
  input  drSel_e          sel,
  input  logic            bsrTdo,
  output logic [IR_W-1:0] instr,
  output logic            tdo,
  output logic            tdoEn,
  output logic            resetHold
);

  logic [IR_W-1:0] irShift;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  logic            tdoNext;
  logic            shifting;

  // Instruction shift stage: rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                irShift <= IR_CAPTURE;
    else if (strobe.captureIr) irShift <= IR_CAPTURE;
    else if (strobe.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Active instruction: falling edge so it is settled for the next state
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)               instr <= OP_IDCODE;
    else if (strobe.tlr)      instr <= OP_IDCODE;
    else if (strobe.updateIr) instr <= irShift;
  end

  // Identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idShift <= '0;
    else if (sel == selIdent) begin
      if (strobe.captureDr)    idShift <= ID_VALUE;
      else if (strobe.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // Bypass register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypassBit <= 1'b0;
    else if (sel == selBypass) begin
      if (strobe.captureDr)    bypassBit <= 1'b0;
      else if (strobe.shiftDr) bypassBit <= tdi;
    end
  end

  // Reset register: a bare flop fed from TDI on the data-register clock
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                   resetHold <= 1'b0;
    else if (strobe.tlr)                          resetHold <= 1'b0;
    else if (strobe.shiftDr && sel == selRstReg)  resetHold <= tdi;
  end

  always_comb begin
    if (strobe.shiftIr) tdoNext = irShift[0];
    else begin
      unique case (sel)
        selBoundary: tdoNext = bsrTdo;
        selIdent:    tdoNext = idShift[0];
        selRstReg:   tdoNext = resetHold;
        default:     tdoNext = bypassBit;
      endcase
    end
  end

  assign shifting = strobe.shiftIr | strobe.shiftDr;

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= shifting ? tdoNext : 1'b0;
      tdoEn <= shifting;
    end
  end

endmodule

// File: rtl/tapSelect.sv
module tapSelect
  import tapPkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA7C1,
  parameter logic [10:0] ID_MFR     = 11'h01F
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  input  logic bsrTdo,
  output logic bsrSelect,
  output logic captureDr,
  output logic shiftDr,
  output logic updateDr,
  input  logic sysResetIn,
  output logic resetHold,
  output logic coreReset
);

  localparam int ID_W = 4 + 16 + 11 + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tapStrobe_t      strobe;
  drSel_e          sel;
  logic [IR_W-1:0] instr;

  tapCtrl uCtrl (
    .tck    (tck),
    .trstN  (trstN),
    .tms    (tms),
    .strobe (strobe)
  );

  tapDecode uDecode (
    .instr     (instr),
    .sel       (sel),
    .bsrSelect (bsrSelect)
  );

  tapDatapath #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) uPath (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .strobe    (strobe),
    .sel       (sel),
    .bsrTdo    (bsrTdo),
    .instr     (instr),
    .tdo       (tdo),
    .tdoEn     (tdoEn),
    .resetHold (resetHold)
  );

  assign captureDr = strobe.captureDr;
  assign shiftDr   = strobe.shiftDr;
  assign updateDr  = strobe.updateDr;
  assign coreReset = sysResetIn | resetHold;

endmodule

// File: rtl/tapSelectChecker.sv
module tapSelectChecker (
  input logic tck,
  input logic trstN,
  input logic captureDr,
  input logic shiftDr,
  input logic updateDr,
  input logic shiftIr,
  input logic tdoEn,
  input logic resetHold,
  input logic sysResetIn,
  input logic coreReset
);

  AST_DR_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({captureDr, shiftDr, updateDr})); // R2

  AST_CAPTURE_NO_UPDATE: assert property (@(posedge tck) disable iff (!trstN)
    captureDr |=> !updateDr && !captureDr); // R2

  AST_UPDATE_NO_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    updateDr |=> !shiftDr && !updateDr); // R2

  AST_TDO_EN_WINDOW: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (shiftDr || shiftIr)); // R9

  AST_HOLD_SET_IN_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    $rose(resetHold) |-> $past(shiftDr)); // R6

  AST_SYS_RESET_PASSES: assert property (@(posedge tck) disable iff (!trstN)
    sysResetIn |-> coreReset); // R7

  AST_HOLD_DRIVES_CORE: assert property (@(posedge tck) disable iff (!trstN)
    resetHold |-> coreReset); // R7

endmodule

bind tapSelect tapSelectChecker uChk (
  .tck        (tck),
  .trstN      (trstN),
  .captureDr  (captureDr),
  .shiftDr    (shiftDr),
  .updateDr   (updateDr),
  .shiftIr    (strobe.shiftIr),
  .tdoEn      (tdoEn),
  .resetHold  (resetHold),
  .sysResetIn (sysResetIn),
  .coreReset  (coreReset)
);

// File: tb/tb_tapSelect.sv
module tb_tapSelect;

  logic tck = 1'b0;
  logic trstN, tms, tdi, bsrTdo, sysResetIn;
  logic tdo, tdoEn, bsrSelect, captureDr, shiftDr, updateDr, resetHold, coreReset;

  localparam logic [31:0] EXP_ID = 32'h3A7C_103F;

  tapSelect dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsrTdo(bsrTdo), .bsrSelect(bsrSelect), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .sysResetIn(sysResetIn),
    .resetHold(resetHold), .coreReset(coreReset)
  );

  always #5 tck = ~tck;

  typedef struct { logic val; string tag; int idx; } item_t;
  item_t expQ[$];
  logic  obsQ[$];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic sTdo, sEn, sSel, sCap, sSh, sUpd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops observed TDO bits against the expected queue
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        item_t e;
        logic  o;
        e = expQ.pop_front();
        o = obsQ.pop_front();
        total++;
        if (o !== e.val) begin
          bad++;
          $display("FAIL %s bit %0d actual=%0b expected=%0b", e.tag, e.idx, o, e.val);
        end
      end
    end
  end

  // One TCK period: drive after the falling edge, sample late in the low phase
  task automatic tick(input logic tmsV, input logic tdiV, input logic extNext);
    @(negedge tck);
    #1;
    tms = tmsV;
    tdi = tdiV;
    #2;
    sTdo = tdo; sEn = tdoEn; sSel = bsrSelect;
    sCap = captureDr; sSh = shiftDr; sUpd = updateDr;
    @(posedge tck);
    #1;
    bsrTdo = extNext;
  endtask

  task automatic toReset();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
  endtask

  task automatic scanIr(input logic [3:0] op, input logic expOldSel, input logic expNewSel);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i], 1'b0);
      expQ.push_back('{val: (i == 0), tag: "R3 ir-capture", idx: i});
      obsQ.push_back(sTdo);
      check(sEn === 1'b1, "R9 tdoEn in Shift-IR", sEn, 1);
    end
    tick(1'b1, 1'b0, 1'b0);
    check(sSel === expOldSel, "R3 bsrSelect in Exit1-IR", sSel, expOldSel);
    tick(1'b0, 1'b0, 1'b0);
    check(sSel === expNewSel, "R3 bsrSelect in Update-IR", sSel, expNewSel);
  endtask

  task automatic scanDr(input int n, input logic [31:0] data, input logic [31:0] ext,
                        input logic [31:0] expOut, input string tag);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, ext[0]);
    check(sCap === 1'b1, "R2 captureDr", sCap, 1);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, data[i], (i + 1 < 32) ? ext[(i + 1) % 32] : 1'b0);
      expQ.push_back('{val: expOut[i], tag: tag, idx: i});
      obsQ.push_back(sTdo);
      if (i == 0) begin
        check(sSh === 1'b1, "R2 shiftDr", sSh, 1);
        check(sEn === 1'b1, "R9 tdoEn in Shift-DR", sEn, 1);
      end
    end
    tick(1'b1, 1'b0, 1'b0);
    check(sSh === 1'b0 && sEn === 1'b0, "R9 tdoEn off in Exit1-DR", {sSh, sEn}, 0);
    tick(1'b0, 1'b0, 1'b0);
    check(sUpd === 1'b1, "R2 updateDr", sUpd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    trstN = 1'b0; tms = 1'b1; tdi = 1'b0; bsrTdo = 1'b0; sysResetIn = 1'b0;
    #22;
    trstN = 1'b1;
    #1;
    check(tdoEn === 1'b0, "R1 tdoEn after reset", tdoEn, 0);
    check(resetHold === 1'b0, "R1 resetHold after reset", resetHold, 0);
    check(bsrSelect === 1'b0, "R1 bsrSelect after reset", bsrSelect, 0);
    toReset();
    check(sEn === 1'b0, "R9 tdoEn idle", sEn, 0);

    // R4: IDCODE is the default instruction
    scanDr(32, 32'h0, 32'h0, EXP_ID, "R4 idcode");
    check(EXP_ID[0] === 1'b1, "R4 id lsb", EXP_ID[0], 1);

    // R8: explicit bypass
    scanIr(4'hF, 1'b0, 1'b0);
    scanDr(8, 32'hB5, 32'h0, {24'h0, 8'hB5 << 1}, "R8 bypass 0xF");

    // R8: undefined opcode
    scanIr(4'h5, 1'b0, 1'b0);
    scanDr(8, 32'h6C, 32'h0, {24'h0, 8'h6C << 1}, "R8 bypass 0x5");

    // R5 / R3: boundary scan selection and routing
    scanIr(4'h0, 1'b0, 1'b1);
    check(bsrSelect === 1'b1, "R5 bsrSelect extest", bsrSelect, 1);
    scanDr(12, 32'h0, 32'h0000_0A5C, 32'h0000_0A5C, "R5 extest tdo");

    // R6: reset register loaded while old value goes out
    scanIr(4'hC, 1'b1, 1'b0);
    check(bsrSelect === 1'b0, "R5 bsrSelect off", bsrSelect, 0);
    scanDr(1, 32'h1, 32'h0, 32'h0, "R6 rstreg old 0");
    check(resetHold === 1'b1, "R6 hold set", resetHold, 1);
    check(coreReset === 1'b1, "R7 core from hold", coreReset, 1);

    // R7: survives instruction change
    scanIr(4'hF, 1'b0, 1'b0);
    check(resetHold === 1'b1, "R7 hold persists", resetHold, 1);

    // R6: two-bit scan, then clear
    scanIr(4'hC, 1'b0, 1'b0);
    scanDr(2, 32'h1, 32'h0, 32'h3, "R6 rstreg two-bit");
    check(resetHold === 1'b0, "R6 hold cleared", resetHold, 0);
    check(coreReset === 1'b0, "R7 core idle", coreReset, 0);
    sysResetIn = 1'b1;
    #1;
    check(coreReset === 1'b1, "R7 core from sys", coreReset, 1);
    sysResetIn = 1'b0;

    // R1: TMS reset clears hold and restores IDCODE
    scanDr(1, 32'h1, 32'h0, 32'h0, "R6 rstreg set again");
    check(resetHold === 1'b1, "R6 hold set again", resetHold, 1);
    toReset();
    check(resetHold === 1'b0, "R1 hold cleared by tms reset", resetHold, 0);
    scanDr(32, 32'h0, 32'h0, EXP_ID, "R1 idcode after tms reset");

    // R1: asynchronous reset restores IDCODE
    scanIr(4'h0, 1'b0, 1'b1);
    @(negedge tck);
    trstN = 1'b0;
    #2;
    check(bsrSelect === 1'b0, "R1 async reset instr", bsrSelect, 0);
    check(tdoEn === 1'b0, "R1 async reset tdoEn", tdoEn, 0);
    trstN = 1'b1;
    tick(1'b0, 1'b0, 1'b0);

    wait (obsQ.size() == 0);
    #1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule